// File: doc/BRIEF.md
# Dual 32-bit Timer Pair

This peripheral holds two 32-bit count-up timer halves, low and high, that together make up one 64-bit timer slot. Each half has its own counter, its own period register and its own interrupt line. Software programs the block through a flat memory-mapped register port. A global control register holds the per-half reset releases and the timer-mode selector. A shared control register holds one 2-bit enable field for each half, and each field sits at its own bit position.

Counting takes place only in the 32-bit unchained mode. A released and enabled half advances by one each clock. When the counter equals the period, the counter returns to zero and the half raises its interrupt for one cycle. In periodic mode the half keeps running after that. In one-shot mode the half clears its own enable field and stops. Software can overwrite a counter at any time. A counter read returns the live value in the same cycle.

Top module: `timer_pair_top`

## Requirements
- R1: After reset, every counter, period, control and global control register reads 0 and both interrupts are low. The identification register at offset 0x00 reads the `ID_VALUE` parameter, default 0x54430001, and any unmapped offset reads 0.
- R2: The register offsets are: low counter 0x10, high counter 0x14, low period 0x18, high period 0x1C, control 0x20 and global control 0x24. Period registers read back as written. The control register keeps only bits [7:6] (low-half enable) and [23:22] (high-half enable), and all other control bits read 0. Global control keeps only bits [3:0].
- R3: A half counts when its global control release bit is 1, the global mode field [3:2] equals 1 (32-bit unchained) and its enable code is 1 or 2. While counting, and below its period, the half adds 1 to its counter every clock.
- R4: Global control bit 0 releases the low half and bit 1 releases the high half. While a release bit is 0, that half's counter is 0, counter writes to it are ignored and its interrupt stays low.
- R5: If the global mode field is any value other than 1, a released half holds its counter value. It neither counts nor clears.
- R6: Enable code 2 is periodic. In the cycle after the counter equals the period, the counter reads 0 and the interrupt is high for that one cycle, after which counting continues. The cycle length is period+1 clocks, and a period of 0 keeps the interrupt high on every clock.
- R7: Enable code 1 is one-shot. The match behaves as in R6, and then the half's enable field reads back 0 and the counter stays at 0.
- R8: Enable codes 0 and 3 do not count. The counter holds its value.
- R9: A write to a released half's counter takes effect at the next clock and overrides counting and matching in that cycle. Writing 0 restarts the count.
- R10: With the period set to 0xFFFFFFFF, the counter counts through 0xFFFFFFFF and then wraps to 0 with an interrupt.
- R11: The two halves run independently. Each half's period, enable and release affect only its own counter and its own interrupt.
- R12: Register reads are combinational from the address, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register byte offset |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| irqLo | output | 1 | Low-half match interrupt, one-cycle pulse |
| irqHi | output | 1 | High-half match interrupt, one-cycle pulse |

## Verification
The bench sweeps the period from 0 to 6 in both periodic and one-shot modes and compares the counter and interrupt on every cycle against k mod (period+1). This sweep catches an off-by-one cycle length, an interrupt held for two cycles, and a one-shot that keeps running. Period 0 and the all-ones wrap are the edge cases: at period 0 a design that compares after incrementing would never match, and at all ones a design that skips the match would wrap without an interrupt. Other runs hold the low half in reset while the high half runs, switch the global mode field away from unchained, and try enable code 3. These catch leakage between halves, counting in a mode that should not count, and a counter that is cleared when it should hold.

// File: rtl/timer_pair_pkg.sv
package timer_pair_pkg;

  localparam int NUM_HALVES = 2;

  // byte offsets decoded by software
  localparam logic [7:0] OFS_ID    = 8'h00;
  localparam logic [7:0] OFS_CNT0  = 8'h10;
  localparam logic [7:0] OFS_PRD0  = 8'h18;
  localparam logic [7:0] OFS_CTRL  = 8'h20;
  localparam logic [7:0] OFS_GLB   = 8'h24;

  // enable field position of each half in the control word
  localparam int MODE_POS [NUM_HALVES] = '{6, 22};

  localparam logic [1:0] EN_OFF  = 2'd0;
  localparam logic [1:0] EN_ONCE = 2'd1;
  localparam logic [1:0] EN_LOOP = 2'd2;

  localparam logic [1:0] GMODE_UNCHAINED = 2'd1;

  typedef struct packed {
    logic released;
    logic counting;
    logic oneShot;
    logic wrCnt;
    logic wrPrd;
  } halfCtl_t;

endpackage

// File: rtl/timer_pair_half.sv
module timer_pair_half
  import timer_pair_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  halfCtl_t         ctl,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] prd,
  output logic             irq,
  output logic             oneShotDone
);

  logic hit;

  assign hit         = ctl.counting && !ctl.wrCnt && (cnt == prd);
  assign oneShotDone = hit && ctl.oneShot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
      prd <= '0;
      irq <= 1'b0;
    end else begin
      if (ctl.wrPrd) prd <= wrData;
      if (!ctl.released)     cnt <= '0;
      else if (ctl.wrCnt)    cnt <= wrData;
      else if (hit)          cnt <= '0;
      else if (ctl.counting) cnt <= cnt + 1'b1;
      irq <= hit;
    end
  end

  // R4: a half held in reset stays at zero and silent
  a_r4_reset_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.released |=> (cnt == '0) && !irq);

  // R3: single step while counting below the period
  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    ctl.counting && !ctl.wrCnt && (cnt != prd) |=> cnt == $past(cnt) + 1'b1);

  // R6: an interrupt only follows a match while counting
  a_r6_irq_match: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ($past(cnt) == $past(prd)) && $past(ctl.counting));

  // R9: software counter write lands on the next clock
  a_r9_cnt_write: assert property (@(posedge clk) disable iff (!rstN)
    ctl.released && ctl.wrCnt |=> cnt == $past(wrData));

endmodule

// File: rtl/timer_pair_ctrl.sv
module timer_pair_ctrl
  import timer_pair_pkg::*;
#(
  parameter int          CNT_W    = 32,
  parameter logic [31:0] ID_VALUE = 32'h5443_0001
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [7:0]                           busAddr,
  input  logic                                 busWrEn,
  input  logic [NUM_HALVES-1:0][1:0]           modeWrData,
  input  logic [3:0]                           glbWrData,
  input  logic [NUM_HALVES-1:0][CNT_W-1:0]     cntRd,
  input  logic [NUM_HALVES-1:0][CNT_W-1:0]     prdRd,
  input  logic [NUM_HALVES-1:0]                oneShotDone,
  output halfCtl_t                             ctl [NUM_HALVES],
  output logic [CNT_W-1:0]                     rdData
);

  logic [3:0]                 glbQ;
  logic [NUM_HALVES-1:0][1:0] modeQ;
  logic                       wrCtrl;
  logic                       unchained;
  logic [CNT_W-1:0]           ctrlWord;

  assign wrCtrl    = busWrEn && (busAddr == OFS_CTRL);
  assign unchained = (glbQ[3:2] == GMODE_UNCHAINED);

  always_ff @(posedge clk) begin
    if (!rstN) glbQ <= '0;
    else if (busWrEn && (busAddr == OFS_GLB)) glbQ <= glbWrData;
  end

  for (genvar i = 0; i < NUM_HALVES; i++) begin : g_half
    localparam logic [7:0] CNT_OFS = OFS_CNT0 + 8'(4 * i);
    localparam logic [7:0] PRD_OFS = OFS_PRD0 + 8'(4 * i);

    always_ff @(posedge clk) begin
      if (!rstN)              modeQ[i] <= EN_OFF;
      else if (wrCtrl)        modeQ[i] <= modeWrData[i];
      else if (oneShotDone[i]) modeQ[i] <= EN_OFF;
    end

    always_comb begin
      ctl[i].released = glbQ[i];
      ctl[i].counting = glbQ[i] && unchained &&
                        ((modeQ[i] == EN_ONCE) || (modeQ[i] == EN_LOOP));
      ctl[i].oneShot  = (modeQ[i] == EN_ONCE);
      ctl[i].wrCnt    = busWrEn && (busAddr == CNT_OFS);
      ctl[i].wrPrd    = busWrEn && (busAddr == PRD_OFS);
    end

    // R7: a finished one-shot disables itself unless software rewrites control
    a_r7_oneshot_clear: assert property (@(posedge clk) disable iff (!rstN)
      oneShotDone[i] && !wrCtrl |=> modeQ[i] == EN_OFF);
  end

  always_comb begin
    ctrlWord = '0;
    for (int i = 0; i < NUM_HALVES; i++) ctrlWord[MODE_POS[i] +: 2] = modeQ[i];
  end

  always_comb begin
    rdData = '0;
    case (busAddr)
      OFS_ID:   rdData = ID_VALUE;
      OFS_CTRL: rdData = ctrlWord;
      OFS_GLB:  rdData = {{(CNT_W-4){1'b0}}, glbQ};
      default: begin
        for (int i = 0; i < NUM_HALVES; i++) begin
          if (busAddr == OFS_CNT0 + 8'(4 * i)) rdData = cntRd[i];
          if (busAddr == OFS_PRD0 + 8'(4 * i)) rdData = prdRd[i];
        end
      end
    endcase
  end

endmodule

// File: rtl/timer_pair_top.sv
module timer_pair_top
  import timer_pair_pkg::*;
#(
  parameter int          CNT_W    = 32,
  parameter logic [31:0] ID_VALUE = 32'h5443_0001
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       busAddr,
  input  logic             busWrEn,
  input  logic [CNT_W-1:0] busWrData,
  output logic [CNT_W-1:0] busRdData,
  output logic             irqLo,
  output logic             irqHi
);

  halfCtl_t                           ctl [NUM_HALVES];
  logic [NUM_HALVES-1:0][CNT_W-1:0]   cntAll;
  logic [NUM_HALVES-1:0][CNT_W-1:0]   prdAll;
  logic [NUM_HALVES-1:0]              irqAll;
  logic [NUM_HALVES-1:0]              doneAll;
  logic [NUM_HALVES-1:0][1:0]         modeWr;

  for (genvar i = 0; i < NUM_HALVES; i++) begin : g_half
    assign modeWr[i] = busWrData[MODE_POS[i] +: 2];

    timer_pair_half #(.CNT_W(CNT_W)) u_half (
      .clk        (clk),
      .rstN       (rstN),
      .ctl        (ctl[i]),
      .wrData     (busWrData),
      .cnt        (cntAll[i]),
      .prd        (prdAll[i]),
      .irq        (irqAll[i]),
      .oneShotDone(doneAll[i])
    );
  end

  timer_pair_ctrl #(.CNT_W(CNT_W), .ID_VALUE(ID_VALUE)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWrEn    (busWrEn),
    .modeWrData (modeWr),
    .glbWrData  (busWrData[3:0]),
    .cntRd      (cntAll),
    .prdRd      (prdAll),
    .oneShotDone(doneAll),
    .ctl        (ctl),
    .rdData     (busRdData)
  );

  assign irqLo = irqAll[0];
  assign irqHi = irqAll[1];

endmodule

// File: tb/tb_timer_pair_top.sv
module tb_timer_pair_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqLo, irqHi;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  timer_pair_top dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    #1 busWrEn = 1'b0;
  endtask

  // sample at the negedge following the last write edge
  task automatic peek(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state, R12 combinational reads
    peek(8'h00, v); check("R1 id", v, 32'h5443_0001);
    foreach (v[i]) ; // no-op
    for (int a = 8'h10; a <= 8'h28; a += 4) begin
      peek(8'(a), v); check("R1 reset reg", v, 32'h0);
    end
    check("R1 irqLo", {31'b0, irqLo}, 32'h0);
    check("R1 irqHi", {31'b0, irqHi}, 32'h0);

    // R2 readback masking
    wr(8'h18, 32'hDEAD_BEEF); peek(8'h18, v); check("R2 prd lo", v, 32'hDEAD_BEEF);
    wr(8'h1C, 32'h1234_5678); peek(8'h1C, v); check("R2 prd hi", v, 32'h1234_5678);
    wr(8'h20, 32'hFFFF_FFFF); peek(8'h20, v); check("R2 ctrl mask", v, 32'h00C0_00C0);
    wr(8'h24, 32'hFFFF_FFFF); peek(8'h24, v); check("R2 glb mask", v, 32'h0000_000F);

    wr(8'h24, 32'h7);   // unchained, both released

    // R6 periodic sweep, R3 stepping
    for (int p = 0; p <= 6; p++) begin
      wr(8'h20, 32'h0);
      wr(8'h18, 32'(p));
      wr(8'h10, 32'h0);
      wr(8'h20, 32'(2) << 6);
      for (int k = 0; k < 12; k++) begin
        peek(8'h10, v);
        check("R6 R3 periodic cnt", v, 32'(k % (p + 1)));
        check("R6 periodic irq", {31'b0, irqLo}, {31'b0, (k > 0) && (k % (p + 1) == 0)});
      end
    end

    // R7 one-shot sweep
    for (int p = 0; p <= 6; p++) begin
      wr(8'h20, 32'h0);
      wr(8'h18, 32'(p));
      wr(8'h10, 32'h0);
      wr(8'h20, 32'(1) << 6);
      for (int k = 0; k < 10; k++) begin
        peek(8'h10, v);
        check("R7 oneshot cnt", v, (k <= p) ? 32'(k) : 32'h0);
        check("R7 oneshot irq", {31'b0, irqLo}, {31'b0, k == p + 1});
      end
      peek(8'h20, v); check("R7 enable cleared", v, 32'h0);
    end

    // R10 all-ones wrap, R9 write while running
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h20, 32'(2) << 6);
    wr(8'h10, 32'hFFFF_FFFD);
    for (int k = 0; k < 5; k++) begin
      peek(8'h10, v);
      check("R10 R9 wrap cnt", v, 32'hFFFF_FFFD + 32'(k));
      check("R10 wrap irq", {31'b0, irqLo}, {31'b0, k == 3});
    end

    // R4 low in reset, R11 high runs alone
    wr(8'h20, 32'h0);
    wr(8'h18, 32'd100);
    wr(8'h1C, 32'd3);
    wr(8'h14, 32'h0);
    wr(8'h24, 32'h6);
    wr(8'h10, 32'd5);                      // ignored
    wr(8'h20, (32'(2) << 22) | (32'(2) << 6));
    for (int k = 0; k < 12; k++) begin
      peek(8'h10, v);
      check("R4 lo held at zero", v, 32'h0);
      check("R4 lo irq low", {31'b0, irqLo}, 32'h0);
      check("R11 hi irq", {31'b0, irqHi}, {31'b0, (k > 0) && (k % 4 == 0)});
    end

    // R5 global mode not unchained holds counter
    wr(8'h20, 32'h0);
    wr(8'h24, 32'h3);
    wr(8'h10, 32'd7);
    wr(8'h20, 32'(2) << 6);
    for (int k = 0; k < 5; k++) begin
      peek(8'h10, v); check("R5 hold in other mode", v, 32'd7);
    end
    wr(8'h24, 32'h7);
    for (int k = 0; k < 3; k++) begin
      peek(8'h10, v); check("R5 resume", v, 32'd7 + 32'(k));
    end

    // R8 enable code 3 holds
    wr(8'h20, 32'(3) << 6);
    peek(8'h10, v);
    begin
      logic [31:0] held;
      held = v;
      for (int k = 0; k < 4; k++) begin
        peek(8'h10, v); check("R8 code3 hold", v, held);
      end
    end
    wr(8'h20, 32'h0);
    peek(8'h10, v);
    begin
      logic [31:0] held0;
      held0 = v;
      peek(8'h10, v); check("R8 code0 hold", v, held0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule